// File: doc/BRIEF.md
# Serial FIFO Interrupt Status Controller

This block gathers every interrupt cause of a synchronous serial port with one transmit FIFO and one receive FIFO and folds them into a single maskable interrupt line. It does not hold the FIFO data. It sees each FIFO only as an occupancy count. It also receives strobes from the CPU side (FIFO write, FIFO read) and from the serial side (transmit slot, received word, frame-sync pulse, bit tick).

Four status bits follow the live FIFO levels. Five error bits are sticky and stay set until software writes 1 to them. One of these errors is a frame-sync timing error, which is checked only in slave mode. Software reads the status register and programs an enable register through a simple register write port. The interrupt line is high whenever an enabled status bit is set.

Top module: `sfifo_irq_ctrl`

## Requirements
- R1: Status bit 0 (transmit request) is 1 exactly when the sampled transmit count is at least the transmit threshold.
- R2: Status bit 1 (transmit empty) is 1 exactly when the sampled transmit count is 0.
- R3: Status bit 2 (receive request) is 1 exactly when the sampled receive count is at least the receive threshold.
- R4: Status bit 3 (receive full) is 1 exactly when the sampled receive count equals the receive depth.
- R5: Status bit 4 (transmit underflow) is set when a transmit slot strobe occurs while the transmit count is 0.
- R6: Status bit 5 (transmit overflow) is set when a CPU transmit write occurs while the transmit count equals its depth.
- R7: Status bit 6 (receive overflow) is set when a received-word strobe occurs while the receive count equals its depth.
- R8: Status bit 7 (receive underflow) is set when a CPU receive read occurs while the receive count is 0.
- R9: Status bit 8 (frame-sync error) is set when, in slave mode, a sync pulse arrives after an earlier sync pulse, and fewer bit ticks than the programmed bits-per-frame have been counted since that earlier pulse. Bit ticks in the sync cycle are not counted. The bit counter saturates. The first sync after reset never flags. Sync pulses in master mode never flag.
- R10: Error bits 8..4 hold until a status write (select 0) with a 1 in that bit position. Writing to bits 3..0 has no effect on them.
- R11: When an error event and a write-1-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R12: The interrupt output is 1 exactly when some status bit and the enable bit at the same position are both 1.
- R13: An enable write (select 1) loads all 9 enable bits from the write data, and the enable register reads back that value.
- R14: After reset, the error bits, the enable register and the interrupt output are 0.
- All status and enable updates appear one clock after the cycle of the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_thresh | input | CNT_W | Transmit request threshold |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_thresh | input | CNT_W | Receive request threshold |
| cpu_tx_wr | input | 1 | CPU writes the transmit FIFO |
| cpu_rx_rd | input | 1 | CPU reads the receive FIFO |
| ser_tx_slot | input | 1 | Serializer takes a transmit word |
| ser_rx_word | input | 1 | Serializer delivers a received word |
| fsync | input | 1 | Frame-sync pulse |
| bit_tick | input | 1 | One serial bit elapsed |
| slave_mode | input | 1 | 1 = slave mode, enables the sync check |
| frame_bits | input | BW | Programmed bits per frame |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = status (write-1-clear), 1 = enable |
| reg_wdata | input | 9 | Register write data |
| status_q | output | 9 | Status register |
| enable_q | output | 9 | Enable register |
| irq | output | 1 | Interrupt request |

## Verification
Every status bit and enable bit is registered once, so a stimulus driven before rising edge N appears in the outputs right after edge N. The interrupt follows from the registers with no further delay. The bench drives inputs on the falling edge and computes its expected register values for the edge that follows. It compares those values one falling edge later, so each sample lands one full register stage after its cause. The bench keeps its own bit counter and first-frame flag, updated on the same edges, so frame-sync error expectations line up cycle for cycle with the design.

// File: rtl/sfifo_irq_pkg.sv
package sfifo_irq_pkg;
    localparam int NSTAT = 9;

    localparam int B_TXREQ = 0;
    localparam int B_TXEMP = 1;
    localparam int B_RXREQ = 2;
    localparam int B_RXFUL = 3;
    localparam int B_TXUDF = 4;
    localparam int B_TXOVF = 5;
    localparam int B_RXOVF = 6;
    localparam int B_RXUDF = 7;
    localparam int B_FSERR = 8;

    localparam logic [NSTAT-1:0] ERR_MASK = 9'h1F0;

    typedef struct packed {
        logic [NSTAT-1:0] status;
        logic [NSTAT-1:0] enable;
    } irq_regs_t;
endpackage

// File: rtl/sfifo_level_flags.sv
module sfifo_level_flags #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    output logic             empty,
    output logic             full,
    output logic             req
);
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

    always_comb begin
        empty = (count == '0);
        full  = (count == FULL_V);
        req   = (count >= thresh);
    end
endmodule

// File: rtl/sfifo_frame_check.sv
module sfifo_frame_check #(
    parameter int BW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slave_mode,
    input  logic          fsync,
    input  logic          bit_tick,
    input  logic [BW-1:0] frame_bits,
    output logic          fs_err_evt
);
    localparam logic [BW-1:0] CNT_MAX = {BW{1'b1}};

    typedef struct packed {
        logic [BW-1:0] bit_cnt;
        logic          in_frame;
    } fc_state_t;

    fc_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        fs_err_evt = slave_mode && fsync && cur_q.in_frame
                     && (cur_q.bit_cnt < frame_bits);
        if (fsync) begin
            nxt_d.bit_cnt  = '0;
            nxt_d.in_frame = 1'b1;
        end else if (bit_tick && cur_q.bit_cnt != CNT_MAX) begin
            nxt_d.bit_cnt = cur_q.bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R9
    first_sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !cur_q.in_frame) |-> !fs_err_evt);

    // R9
    sync_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (cur_q.bit_cnt == '0 && cur_q.in_frame));
endmodule

// File: rtl/sfifo_irq_ctrl.sv
module sfifo_irq_ctrl
    import sfifo_irq_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    parameter int CNT_W    = $clog2(((TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH) + 1),
    parameter int BW       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_thresh,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_thresh,
    input  logic             cpu_tx_wr,
    input  logic             cpu_rx_rd,
    input  logic             ser_tx_slot,
    input  logic             ser_rx_word,
    input  logic             fsync,
    input  logic             bit_tick,
    input  logic             slave_mode,
    input  logic [BW-1:0]    frame_bits,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [8:0]       reg_wdata,
    output logic [8:0]       status_q,
    output logic [8:0]       enable_q,
    output logic             irq
);
    logic tx_empty, tx_full, tx_req;
    logic rx_empty, rx_full, rx_req;
    logic fs_evt;

    sfifo_level_flags #(.DEPTH(TX_DEPTH), .CNT_W(CNT_W)) u_tx_lvl (
        .count(tx_count), .thresh(tx_thresh),
        .empty(tx_empty), .full(tx_full), .req(tx_req)
    );

    sfifo_level_flags #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_rx_lvl (
        .count(rx_count), .thresh(rx_thresh),
        .empty(rx_empty), .full(rx_full), .req(rx_req)
    );

    sfifo_frame_check #(.BW(BW)) u_fchk (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .fsync(fsync), .bit_tick(bit_tick), .frame_bits(frame_bits),
        .fs_err_evt(fs_evt)
    );

    irq_regs_t   regs_q, regs_d;
    logic [NSTAT-1:0] evt_d, clr_d;

    always_comb begin
        regs_d = regs_q;

        evt_d          = '0;
        evt_d[B_TXUDF] = ser_tx_slot & tx_empty;
        evt_d[B_TXOVF] = cpu_tx_wr   & tx_full;
        evt_d[B_RXOVF] = ser_rx_word & rx_full;
        evt_d[B_RXUDF] = cpu_rx_rd   & rx_empty;
        evt_d[B_FSERR] = fs_evt;

        clr_d = (reg_wr_en && !reg_wr_sel) ? (reg_wdata & ERR_MASK) : '0;

        regs_d.status[B_TXREQ] = tx_req;
        regs_d.status[B_TXEMP] = tx_empty;
        regs_d.status[B_RXREQ] = rx_req;
        regs_d.status[B_RXFUL] = rx_full;
        regs_d.status = (regs_d.status & ~clr_d) | evt_d;

        if (reg_wr_en && reg_wr_sel) regs_d.enable = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign status_q = regs_q.status;
    assign enable_q = regs_q.enable;
    assign irq      = |(regs_q.status & regs_q.enable);

    // R2
    txemp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |=> status_q[B_TXEMP]);

    // R5
    txudf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_slot && tx_count == '0) |=> status_q[B_TXUDF]);

    // R10
    fserr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[B_FSERR] && !(reg_wr_en && !reg_wr_sel && reg_wdata[B_FSERR]))
        |=> status_q[B_FSERR]);

    // R11
    rxovf_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_word && rx_count == CNT_W'(RX_DEPTH)
         && reg_wr_en && !reg_wr_sel && reg_wdata[B_RXOVF]) |=> status_q[B_RXOVF]);

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq);
endmodule

// File: tb/tb_sfifo_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sfifo_irq_ctrl;
    localparam int DEPTH = 16;
    localparam int CW    = 5;
    localparam int BW    = 6;
    localparam int NCYC  = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] tx_count = '0, tx_thresh = '0, rx_count = '0, rx_thresh = '0;
    logic cpu_tx_wr = 0, cpu_rx_rd = 0, ser_tx_slot = 0, ser_rx_word = 0;
    logic fsync = 0, bit_tick = 0, slave_mode = 0;
    logic [BW-1:0] frame_bits = '0;
    logic reg_wr_en = 0, reg_wr_sel = 0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] status_q, enable_q;
    logic irq;

    always #2.5 clk = ~clk;

    sfifo_irq_ctrl #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH), .CNT_W(CW), .BW(BW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .tx_thresh(tx_thresh),
        .rx_count(rx_count), .rx_thresh(rx_thresh), .cpu_tx_wr(cpu_tx_wr),
        .cpu_rx_rd(cpu_rx_rd), .ser_tx_slot(ser_tx_slot), .ser_rx_word(ser_rx_word),
        .fsync(fsync), .bit_tick(bit_tick), .slave_mode(slave_mode),
        .frame_bits(frame_bits), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .status_q(status_q), .enable_q(enable_q), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [8:0] exp_st = '0, exp_en = '0;
    logic [BW-1:0] m_cnt = '0;
    bit m_inframe = 0;

    function automatic string tag_of(int b);
        case (b)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
            4: return "R5"; 5: return "R6"; 6: return "R7"; 7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] next_status(logic [8:0] st);
        logic [8:0] n, ev, clr;
        bit fe;
        n    = st;
        n[0] = (tx_count >= tx_thresh);
        n[1] = (tx_count == 0);
        n[2] = (rx_count >= rx_thresh);
        n[3] = (rx_count == DEPTH);
        fe   = slave_mode && fsync && m_inframe && (m_cnt < frame_bits);
        ev   = {fe, cpu_rx_rd && rx_count == 0, ser_rx_word && rx_count == DEPTH,
                cpu_tx_wr && tx_count == DEPTH, ser_tx_slot && tx_count == 0, 4'b0};
        clr  = (reg_wr_en && !reg_wr_sel) ? (reg_wdata & 9'h1F0) : 9'h0;
        n[8:4] = (st[8:4] & ~clr[8:4]) | ev[8:4];
        return n;
    endfunction

    // Called after inputs are driven (negedge); predicts registers after next posedge.
    task automatic predict();
        exp_st = next_status(exp_st);
        if (reg_wr_en && reg_wr_sel) exp_en = reg_wdata;
        if (fsync) begin
            m_cnt = '0; m_inframe = 1;
        end else if (bit_tick && m_cnt != {BW{1'b1}}) begin
            m_cnt = m_cnt + 1'b1;
        end
    endtask

    task automatic compare_all();
        for (int b = 0; b < 9; b++) begin
            checks++;
            if (status_q[b] !== exp_st[b]) begin
                errors++;
                $display("FAIL %s status bit %0d: actual=%b expected=%b",
                         tag_of(b), b, status_q[b], exp_st[b]);
            end
        end
        chk("R13", enable_q, exp_en, "enable");
        chk("R12", {8'h0, irq}, {8'h0, |(exp_st & exp_en)}, "irq");
    endtask

    task automatic idle();
        cpu_tx_wr = 0; cpu_rx_rd = 0; ser_tx_slot = 0; ser_rx_word = 0;
        fsync = 0; bit_tick = 0; reg_wr_en = 0;
    endtask

    task automatic step();
        predict();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [CW-1:0] rnd_cnt();
        int r = $urandom_range(0, 9);
        if (r < 2) return '0;
        if (r < 4) return CW'(DEPTH);
        return CW'($urandom_range(0, DEPTH));
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R14 reset state
        chk("R14", status_q & 9'h1F0, 9'h0, "errors after reset");
        chk("R14", enable_q, 9'h0, "enable after reset");
        chk("R14", {8'h0, irq}, 9'h0, "irq after reset");
        rst_n = 1;
        @(negedge clk);

        // R13 enable write, R12 irq
        idle(); tx_count = 0; reg_wr_en = 1; reg_wr_sel = 1; reg_wdata = 9'h1FF;
        step();
        chk("R13", enable_q, 9'h1FF, "enable readback");
        idle();

        // R9: first sync after reset in slave mode does not flag
        slave_mode = 1; frame_bits = 6'd4; fsync = 1;
        step(); idle();
        chk("R9", {8'h0, status_q[8]}, 9'h0, "first sync");
        bit_tick = 1; step(); step(); idle();
        fsync = 1; step(); idle();
        chk("R9", {8'h0, status_q[8]}, 9'h1, "early sync flags");
        // R10: write to level bits has no effect on errors; W1C then clears
        reg_wr_en = 1; reg_wr_sel = 0; reg_wdata = 9'h00F; step(); idle();
        chk("R10", {8'h0, status_q[8]}, 9'h1, "non-matching clear");
        reg_wr_en = 1; reg_wr_sel = 0; reg_wdata = 9'h100; step(); idle();
        chk("R10", {8'h0, status_q[8]}, 9'h0, "w1c clears");
        // R9: full frame of bits gives no error
        bit_tick = 1; repeat (4) step(); idle();
        fsync = 1; step(); idle();
        chk("R9", {8'h0, status_q[8]}, 9'h0, "on-time sync");
        // R9: master mode never flags
        slave_mode = 0; fsync = 1; step(); idle();
        chk("R9", {8'h0, status_q[8]}, 9'h0, "master mode");

        // R11: receive overflow with simultaneous clear
        rx_count = CW'(DEPTH); ser_rx_word = 1;
        reg_wr_en = 1; reg_wr_sel = 0; reg_wdata = 9'h040;
        step(); idle();
        chk("R11", {8'h0, status_q[6]}, 9'h1, "event beats clear");
        reg_wr_en = 1; reg_wr_sel = 0; reg_wdata = 9'h1F0; step(); idle();

        // R12: masked status keeps irq low
        reg_wr_en = 1; reg_wr_sel = 1; reg_wdata = 9'h000; step(); idle();
        chk("R12", {8'h0, irq}, 9'h0, "all masked");

        // Constrained random mix
        for (int c = 0; c < NCYC; c++) begin
            tx_count    = rnd_cnt();
            rx_count    = rnd_cnt();
            tx_thresh   = CW'($urandom_range(0, DEPTH));
            rx_thresh   = CW'($urandom_range(0, DEPTH));
            cpu_tx_wr   = ($urandom_range(0, 3) == 0);
            cpu_rx_rd   = ($urandom_range(0, 3) == 0);
            ser_tx_slot = ($urandom_range(0, 3) == 0);
            ser_rx_word = ($urandom_range(0, 3) == 0);
            fsync       = ($urandom_range(0, 5) == 0);
            bit_tick    = ($urandom_range(0, 1) == 0);
            if ($urandom_range(0, 63) == 0) slave_mode = ~slave_mode;
            if ($urandom_range(0, 31) == 0) frame_bits = BW'($urandom_range(1, 8));
            reg_wr_en   = ($urandom_range(0, 7) == 0);
            reg_wr_sel  = $urandom_range(0, 1) != 0;
            reg_wdata   = 9'($urandom_range(0, 511));
            step();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule